// File: doc/BRIEF.md
# Write Strobe Qualifier with Hardware Reset Filter

This block sits where the host bus of a parallel NOR-style memory controller meets the internal clock domain. It receives the asynchronous chip-enable, write-enable and output-enable strobes, a supply-good level, a write-protect level and an active-low hardware reset pin. It samples all of these on a fast internal clock and decides which bus writes count as real command writes. A write is counted only when chip enable and write enable are both low together for long enough, output enable stays high, supply is good and no hardware reset is in force. Address and data are captured as the write strobe rises.

The hardware reset pin is filtered. A low pulse shorter than a minimum length is ignored. A longer one raises an abort request to the program/erase engine and a tri-state request for the read outputs. When the pin rises again, a recovery interval runs before the read-ready flag comes back. The glitch limit is a time parameter that is converted to clock cycles. The reset and recovery intervals are counted in cycles.

Top module: `wr_strobe_qual`

## Requirements
- R1: After the clock-domain reset, `wr_acc`, `abort_req` and `out_hiz` are 0, `ready` is 1 and `wr_prot` is 0.
- R2: A combined low of `ce_n` and `we_n` lasting at least MIN_PULSE clock cycles (ceil(GLITCH_PS/CLK_PS), 4 by default) gives exactly one single-cycle `wr_acc` pulse after the strobe rises. `wr_addr` and `wr_data` then hold the bus values present at the rising edge.
- R3: A combined strobe low of MIN_PULSE-1 cycles produces no `wr_acc`.
- R4: If `oe_n` is low while the strobe is low, no write is accepted.
- R5: If `vdd_ok` is low while the strobe is low, no write is accepted.
- R6: `we_n` low with `ce_n` high produces no write. `ce_n` low with `we_n` high also produces no write.
- R7: When `hw_rst_n` stays low for at least RST_MIN_CYC cycles, `abort_req` and `out_hiz` go to 1 and `ready` goes to 0. While this lasts, strobes produce no write.
- R8: A `hw_rst_n` low pulse of RST_MIN_CYC-1 cycles never raises `abort_req` and leaves `ready` at 1.
- R9: After a qualifying reset, `ready` goes high exactly RECOV_CYC+3 cycles after `hw_rst_n` rises. Two of those cycles are synchronizer delay and one is the release of the hold.
- R10: `wr_prot` is 1 for an accepted write made while `wp_n` was low, and 0 when `wp_n` was high. `wp_n` is treated as high (unprotected) until it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset of the clock domain |
| ce_n | input | 1 | Async chip enable, active low |
| we_n | input | 1 | Async write enable, active low |
| oe_n | input | 1 | Async output enable, active low |
| vdd_ok | input | 1 | Supply above write threshold |
| wp_n | input | 1 | Write-protect pin, low = protected |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| addr_in | input | AW | Bus address |
| data_in | input | DW | Bus data |
| wr_acc | output | 1 | Single-cycle accepted-write pulse |
| wr_addr | output | AW | Address captured at the accepted write |
| wr_data | output | DW | Data captured at the accepted write |
| wr_prot | output | 1 | Protection state at the accepted write |
| abort_req | output | 1 | Abort request to the program/erase engine |
| out_hiz | output | 1 | Request to tri-state the read outputs |
| ready | output | 1 | Reads may proceed |

## Verification
The hardest case to reach is an input edge that falls exactly at a threshold. Both the strobe and the reset pin pass through a two-stage synchronizer before they are counted, so a pulse one cycle too short and a pulse of exactly the minimum length differ only after that delay. The bench drives every input on the falling clock edge and holds each low for a chosen number of whole cycles. This places strobe widths of MIN_PULSE-1 and MIN_PULSE, and reset widths of RST_MIN_CYC-1 and longer, exactly on either side of each limit. It then counts the cycles from the reset pin rising to the return of `ready`. Writes attempted during a held reset check that the reset gate and the width counter work together.

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int GLITCH_PS   = 5000,
  parameter int CLK_PS      = 1250,
  parameter int RST_MIN_CYC = 8,
  parameter int RECOV_CYC   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          vdd_ok,
  input  logic          wp_n,
  input  logic          hw_rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_acc,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_prot,
  output logic          abort_req,
  output logic          out_hiz,
  output logic          ready
);
  localparam int MIN_PULSE = (GLITCH_PS + CLK_PS - 1) / CLK_PS;
  localparam int PW  = $clog2(MIN_PULSE + 1);
  localparam int LW  = $clog2(RST_MIN_CYC + 1);
  localparam int RW  = $clog2(RECOV_CYC + 1);
  localparam logic [5:0] SYNC_INIT = 6'b110111;

  logic [5:0]          s1, s2;
  logic [AW+DW-1:0]    bus1, bus2;
  logic [PW-1:0]       pcnt;
  logic [LW-1:0]       lcnt;
  logic [RW-1:0]       rcnt;
  logic                hold;

  wire ce_s   = s2[0];
  wire we_s   = s2[1];
  wire oe_s   = s2[2];
  wire vdd_s  = s2[3];
  wire wp_s   = s2[4];
  wire hrst_s = s2[5];

  wire strobe = ~ce_s & ~we_s;
  wire gate   = oe_s & vdd_s & ~hold;
  wire accept = ~strobe & gate & (pcnt == PW'(MIN_PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= SYNC_INIT;
      s2   <= SYNC_INIT;
      bus1 <= '0;
      bus2 <= '0;
    end else begin
      s1   <= {hw_rst_n, wp_n, vdd_ok, oe_n, we_n, ce_n};
      s2   <= s1;
      bus1 <= {addr_in, data_in};
      bus2 <= bus1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (strobe && gate) begin
      if (pcnt != PW'(MIN_PULSE)) pcnt <= pcnt + PW'(1);
    end else begin
      pcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_acc  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_prot <= 1'b0;
    end else begin
      wr_acc <= accept;
      if (accept) begin
        {wr_addr, wr_data} <= bus2;
        wr_prot            <= ~wp_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= '0;
      rcnt <= '0;
      hold <= 1'b0;
    end else if (!hrst_s) begin
      if (lcnt == LW'(RST_MIN_CYC - 1)) begin
        hold <= 1'b1;
        rcnt <= '0;
      end else begin
        lcnt <= lcnt + LW'(1);
      end
    end else begin
      lcnt <= '0;
      if (hold) begin
        hold <= 1'b0;
        rcnt <= RW'(RECOV_CYC);
      end else if (rcnt != '0) begin
        rcnt <= rcnt - RW'(1);
      end
    end
  end

  assign abort_req = hold;
  assign out_hiz   = hold;
  assign ready     = ~hold & (rcnt == '0);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
  a_r4_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> $past(oe_s && vdd_s));
  a_r7_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !wr_acc);
  a_r7_hiz_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> !ready);
  a_r9_recovery_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_req) |-> !ready);
endmodule

// File: tb/wr_strobe_qual_tb.sv
module wr_strobe_qual_tb;
  localparam int AW = 16, DW = 16;
  localparam int MINP = 4;
  localparam int RMIN = 8;
  localparam int RCV  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vdd_ok = 1'b1, wp_n = 1'b1, hw_rst_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic wr_acc, wr_prot, abort_req, out_hiz, ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests = 0, fails = 0, acc_cnt = 0;
  logic abort_seen = 1'b0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  logic last_p;

  always #2.5 clk = ~clk;

  wr_strobe_qual #(.AW(AW), .DW(DW), .GLITCH_PS(5000), .CLK_PS(1250),
                   .RST_MIN_CYC(RMIN), .RECOV_CYC(RCV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vdd_ok(vdd_ok), .wp_n(wp_n), .hw_rst_n(hw_rst_n), .addr_in(addr_in),
    .data_in(data_in), .wr_acc(wr_acc), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_prot(wr_prot), .abort_req(abort_req), .out_hiz(out_hiz), .ready(ready));

  always @(negedge clk) begin
    if (wr_acc) begin
      acc_cnt <= acc_cnt + 1;
      last_a  <= wr_addr;
      last_d  <= wr_data;
      last_p  <= wr_prot;
    end
    if (abort_req) abort_seen <= 1'b1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic c, input logic w, input int n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr_in = a; data_in = d;
    ce_n = ~c; we_n = ~w;
    cyc(n);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset_state;
    check(wr_acc == 0 && abort_req == 0 && out_hiz == 0, "R1 idle outputs",
          {wr_acc, abort_req, out_hiz}, 0);
    check(ready == 1 && wr_prot == 0, "R1 ready/prot", {ready, wr_prot}, 2);
  endtask

  task automatic t_good_write;
    int c0 = acc_cnt;
    pulse(1, 1, MINP, 16'h1234, 16'hA5C3);
    check(acc_cnt == c0 + 1, "R2 one pulse at min width", acc_cnt - c0, 1);
    check(last_a == 16'h1234 && last_d == 16'hA5C3, "R2 latched addr", last_a, 16'h1234);
    check(last_d == 16'hA5C3, "R2 latched data", last_d, 16'hA5C3);
    c0 = acc_cnt;
    pulse(1, 1, MINP + 7, 16'h0555, 16'h00AA);
    check(acc_cnt == c0 + 1 && last_a == 16'h0555, "R2 long pulse", acc_cnt - c0, 1);
  endtask

  task automatic t_glitch;
    int c0 = acc_cnt;
    pulse(1, 1, MINP - 1, 16'h7777, 16'h1111);
    check(acc_cnt == c0, "R3 short strobe rejected", acc_cnt - c0, 0);
    pulse(1, 1, 1, 16'h7777, 16'h1111);
    check(acc_cnt == c0, "R3 one-cycle strobe rejected", acc_cnt - c0, 0);
  endtask

  task automatic t_oe_block;
    int c0 = acc_cnt;
    oe_n = 1'b0;
    pulse(1, 1, MINP + 2, 16'h2222, 16'h3333);
    oe_n = 1'b1;
    cyc(3);
    check(acc_cnt == c0, "R4 oe low blocks", acc_cnt - c0, 0);
  endtask

  task automatic t_vdd_block;
    int c0 = acc_cnt;
    vdd_ok = 1'b0;
    pulse(1, 1, MINP + 2, 16'h4444, 16'h5555);
    vdd_ok = 1'b1;
    cyc(3);
    check(acc_cnt == c0, "R5 low supply blocks", acc_cnt - c0, 0);
  endtask

  task automatic t_single_strobe;
    int c0 = acc_cnt;
    pulse(0, 1, MINP + 3, 16'h6666, 16'h6666);
    check(acc_cnt == c0, "R6 we alone", acc_cnt - c0, 0);
    pulse(1, 0, MINP + 3, 16'h6666, 16'h6666);
    check(acc_cnt == c0, "R6 ce alone", acc_cnt - c0, 0);
  endtask

  task automatic t_wp;
    wp_n = 1'b0;
    cyc(3);
    pulse(1, 1, MINP, 16'h0F0F, 16'hF0F0);
    check(last_p == 1'b1, "R10 protected write flagged", last_p, 1);
    wp_n = 1'b1;
    cyc(3);
    pulse(1, 1, MINP, 16'h0F0E, 16'hF0F1);
    check(last_p == 1'b0, "R10 unprotected write", last_p, 0);
  endtask

  task automatic t_short_reset;
    abort_seen = 1'b0;
    @(negedge clk);
    hw_rst_n = 1'b0;
    cyc(RMIN - 1);
    hw_rst_n = 1'b1;
    cyc(8);
    check(abort_seen == 1'b0, "R8 short reset ignored", abort_seen, 0);
    check(ready == 1'b1, "R8 ready kept", ready, 1);
  endtask

  task automatic t_long_reset;
    int c0;
    @(negedge clk);
    hw_rst_n = 1'b0;
    cyc(RMIN + 4);
    check(abort_req == 1 && out_hiz == 1, "R7 abort and hiz", {abort_req, out_hiz}, 3);
    check(ready == 0, "R7 not ready in reset", ready, 0);
    c0 = acc_cnt;
    pulse(1, 1, MINP + 3, 16'h9999, 16'h8888);
    check(acc_cnt == c0, "R7 write blocked in reset", acc_cnt - c0, 0);
    hw_rst_n = 1'b1;
    cyc(RCV + 2);
    check(ready == 0, "R9 ready still low", ready, 0);
    cyc(1);
    check(ready == 1, "R9 ready after recovery", ready, 1);
    check(abort_req == 0 && out_hiz == 0, "R9 abort released", {abort_req, out_hiz}, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset_state();
    t_good_write();
    t_glitch();
    t_oe_block();
    t_vdd_block();
    t_single_strobe();
    t_wp();
    t_short_reset();
    t_long_reset();
    t_good_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule